// File: doc/BRIEF.md
# Encoded Sensor Clock Divider

This block derives the master clock for an image sensor from a reference clock that nominally runs at 96 MHz. A 5-bit control code picks one of four behaviours. Two codes hold the output at a fixed level. One code passes the reference clock straight to the output. Every other code divides the reference by the code value. A status flag tells the rest of the chip whether the output is actually toggling.

The divided output comes from a register clocked by the reference. A new code does not cut the current output period short. In divide mode it is picked up at the end of the period, so the output never carries a runt pulse. When the output is static or in bypass, a new code takes effect on the next reference edge. In bypass the output is the reference clock itself, selected through a multiplexer.

Top module: `sclk_div`

## Requirements
- R1: While `rst_n` is low, `sclk_out` and `div_active` are both 0. The effective code resets to 0.
- R2: When the effective code is 0, `sclk_out` stays at 0.
- R3: When the effective code is 1, `sclk_out` stays at 1.
- R4: For an effective code N with 2 <= N <= 30, `sclk_out` is periodic with a period of exactly N reference clock cycles.
- R5: In divide mode, each period starts with a high phase of floor(N/2) reference cycles, followed by a low phase of N - floor(N/2) cycles. Even N therefore gives a 50 % duty cycle, and odd N gives a high phase one cycle shorter than the low phase.
- R6: When the effective code is 31 (all ones), `sclk_out` equals `ref_clk`: high while the reference is high and low while it is low.
- R7: In divide mode, `div_code` is sampled only on the reference edge that ends the current output period. A new code therefore never shortens or stretches a period that has already started. When the effective code is 0, 1 or 31, `div_code` is sampled on every rising reference edge.
- R8: `div_active` is 1 exactly when the effective code is in the range 2 to 31, and 0 for codes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock (nominally 96 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | CODE_W (5) | Control code: 0 static low, 1 static high, 2..30 divide ratio, 31 bypass |
| sclk_out | output | 1 | Generated sensor clock |
| div_active | output | 1 | High while the effective code produces a toggling output |

## Verification
A corrupted phase counter shows at `sclk_out` within one output period, at most 30 reference cycles: a high or low run has the wrong length, or the output fails to toggle. A code register that updates at the wrong time shows as a period that changes length partway through. It also shows as `div_active` falling before the old period has finished. In both cases the error is visible at most one period after the code changes. A wrong bypass select shows within half a reference cycle, because `sclk_out` no longer follows `ref_clk`.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
   // Behaviour selected by a control code
   typedef enum logic [1:0] {
      MODE_LOW  = 2'd0,
      MODE_HIGH = 2'd1,
      MODE_DIV  = 2'd2,
      MODE_PASS = 2'd3
   } div_mode_e;
endpackage

// File: rtl/sclk_div_decode.sv
module sclk_div_decode
   import sclk_div_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic [CODE_W-1:0] code,
   output div_mode_e         mode
);
   localparam logic [CODE_W-1:0] C_LOW  = '0;
   localparam logic [CODE_W-1:0] C_HIGH = CODE_W'(1);
   localparam logic [CODE_W-1:0] C_PASS = {CODE_W{1'b1}};

   always_comb begin
      if (code == C_LOW)       mode = MODE_LOW;
      else if (code == C_HIGH) mode = MODE_HIGH;
      else if (code == C_PASS) mode = MODE_PASS;
      else                     mode = MODE_DIV;
   end
endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core
   import sclk_div_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] eff_code,
   output logic [CODE_W-1:0] div_cnt,
   output logic              phase_q,
   output logic              pass_q,
   output logic              active_q
);
   localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

   div_mode_e         cur_mode;
   div_mode_e         nxt_mode;
   logic              at_boundary;
   logic [CODE_W-1:0] code_nxt;
   logic [CODE_W-1:0] cnt_nxt;
   logic [CODE_W-1:0] half_nxt;
   logic              phase_nxt;

   sclk_div_decode #(.CODE_W(CODE_W)) u_dec_cur (
      .code (eff_code),
      .mode (cur_mode)
   );

   sclk_div_decode #(.CODE_W(CODE_W)) u_dec_nxt (
      .code (code_nxt),
      .mode (nxt_mode)
   );

   // A period ends on its last count; outside divide mode every edge is a boundary
   always_comb begin
      at_boundary = (cur_mode != MODE_DIV) || (div_cnt == (eff_code - ONE));
      code_nxt    = at_boundary ? code_in : eff_code;
      cnt_nxt     = at_boundary ? '0 : (div_cnt + ONE);
      half_nxt    = code_nxt >> 1;
      unique case (nxt_mode)
         MODE_LOW:  phase_nxt = 1'b0;
         MODE_HIGH: phase_nxt = 1'b1;
         MODE_DIV:  phase_nxt = (cnt_nxt < half_nxt);
         default:   phase_nxt = 1'b0;
      endcase
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_code <= '0;
         div_cnt  <= '0;
         phase_q  <= 1'b0;
         pass_q   <= 1'b0;
         active_q <= 1'b0;
      end else begin
         eff_code <= code_nxt;
         div_cnt  <= cnt_nxt;
         phase_q  <= phase_nxt;
         pass_q   <= (nxt_mode == MODE_PASS);
         active_q <= (nxt_mode == MODE_DIV) || (nxt_mode == MODE_PASS);
      end
   end
endmodule

// File: rtl/sclk_div_outmux.sv
module sclk_div_outmux (
   input  logic ref_clk,
   input  logic sel_pass,
   input  logic phase,
   output logic clk_out
);
   assign clk_out = sel_pass ? ref_clk : phase;
endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
   parameter int CODE_W = 5
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] div_code,
   output logic              sclk_out,
   output logic              div_active
);
   // The code space needs room for two static codes, a bypass code and a divide ratio
   if (CODE_W < 2) begin : g_bad_width
      $error("sclk_div: CODE_W must be at least 2");
   end
   if (CODE_W > 8) begin : g_wide_width
      $error("sclk_div: CODE_W above 8 is not supported");
   end

   logic [CODE_W-1:0] eff_code;
   logic [CODE_W-1:0] div_cnt;
   logic              phase_q;
   logic              pass_q;

   sclk_div_core #(.CODE_W(CODE_W)) u_core (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .code_in  (div_code),
      .eff_code (eff_code),
      .div_cnt  (div_cnt),
      .phase_q  (phase_q),
      .pass_q   (pass_q),
      .active_q (div_active)
   );

   sclk_div_outmux u_mux (
      .ref_clk  (ref_clk),
      .sel_pass (pass_q),
      .phase    (phase_q),
      .clk_out  (sclk_out)
   );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk #(
   parameter int CODE_W = 5
) (
   input logic              ref_clk,
   input logic              rst_n,
   input logic              sclk_out,
   input logic              div_active,
   input logic [CODE_W-1:0] eff_code,
   input logic [CODE_W-1:0] div_cnt
);
   localparam logic [CODE_W-1:0] C_PASS = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] ONE    = CODE_W'(1);

   logic in_div;
   assign in_div = (eff_code > ONE) && (eff_code != C_PASS);

   // R1: outputs low while reset is held
   always @(negedge ref_clk) begin
      if (!rst_n) begin
         a_reset_r1: assert (!sclk_out && !div_active)
            else $error("reset state violated");
      end
   end

   p_low_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (eff_code == '0) |-> !sclk_out);

   p_high_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (eff_code == ONE) |-> sclk_out);

   p_cnt_range_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      in_div |-> (div_cnt < eff_code));

   p_wrap_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (in_div && (div_cnt == (eff_code - ONE))) |=> (div_cnt == '0));

   p_bypass_r6: assert property (@(negedge ref_clk) disable iff (!rst_n)
      (eff_code == C_PASS) |-> sclk_out);

   p_hold_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (in_div && (div_cnt != (eff_code - ONE))) |=> $stable(eff_code));
endmodule

bind sclk_div sclk_div_chk #(.CODE_W(CODE_W)) u_chk (
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .sclk_out   (sclk_out),
   .div_active (div_active),
   .eff_code   (eff_code),
   .div_cnt    (div_cnt)
);

// File: tb/sclk_div_bench.sv
`timescale 1ns/1ps
module sclk_div_bench;
   typedef struct packed {
      logic [4:0] code;
      logic [5:0] hi;
      logic [5:0] lo;
      logic       act;
   } vec_t;

   // code, expected high run, expected low run, expected active flag
   localparam vec_t TBL [10] = '{
      '{5'd2,  6'd1,  6'd1,  1'b1},
      '{5'd3,  6'd1,  6'd2,  1'b1},
      '{5'd4,  6'd2,  6'd2,  1'b1},
      '{5'd5,  6'd2,  6'd3,  1'b1},
      '{5'd7,  6'd3,  6'd4,  1'b1},
      '{5'd16, 6'd8,  6'd8,  1'b1},
      '{5'd30, 6'd15, 6'd15, 1'b1},
      '{5'd0,  6'd0,  6'd0,  1'b0},
      '{5'd1,  6'd0,  6'd0,  1'b0},
      '{5'd31, 6'd0,  6'd0,  1'b1}
   };

   logic       ref_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic [4:0] div_code = 5'd5;
   logic       sclk_out;
   logic       div_active;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 ref_clk = ~ref_clk;

   sclk_div u_sclk_div (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .div_code   (div_code),
      .sclk_out   (sclk_out),
      .div_active (div_active)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic smp(output logic v);
      @(negedge ref_clk); #1;
      v = sclk_out;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge ref_clk); #1;
      end
   endtask

   task automatic find_rise(output bit ok);
      logic p, c;
      ok = 1'b0;
      smp(p);
      for (int i = 0; i < 80; i++) begin
         smp(c);
         if (c && !p) begin
            ok = 1'b1;
            return;
         end
         p = c;
      end
   endtask

   // Entered right after a rising sample; returns on the next rising sample
   task automatic measure(output int h, output int l);
      logic c;
      h = 1;
      l = 0;
      for (int i = 0; i < 64; i++) begin
         smp(c);
         if (!c) break;
         h++;
      end
      l = 1;
      for (int i = 0; i < 64; i++) begin
         smp(c);
         if (c) break;
         l++;
      end
   endtask

   task automatic static_check(input string req, input logic lvl);
      logic c;
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
         smp(c);
         if (c !== lvl) bad++;
      end
      chk(req, bad, 0);
   endtask

   initial begin
      bit ok;
      int h, l;
      logic c;

      // R1: reset state with a divide code already present
      wait_cycles(3);
      chk("R1 sclk_out in reset", int'(sclk_out), 0);
      chk("R1 div_active in reset", int'(div_active), 0);
      rst_n = 1'b1;
      div_code = 5'd0;
      wait_cycles(2);

      // Table of codes walked by one loop
      foreach (TBL[k]) begin
         div_code = TBL[k].code;
         wait_cycles(40);
         chk($sformatf("R8 active for code %0d", TBL[k].code), int'(div_active), int'(TBL[k].act));
         if (TBL[k].code == 5'd0) begin
            static_check("R2 static low", 1'b0);
         end else if (TBL[k].code == 5'd1) begin
            static_check("R3 static high", 1'b1);
         end else if (TBL[k].code == 5'd31) begin
            int bad = 0;
            for (int i = 0; i < 4; i++) begin
               @(posedge ref_clk); #1;
               if (sclk_out !== 1'b1) bad++;
               @(negedge ref_clk); #1;
               if (sclk_out !== 1'b0) bad++;
            end
            chk("R6 bypass follows reference", bad, 0);
         end else begin
            find_rise(ok);
            chk($sformatf("R4 toggling for code %0d", TBL[k].code), int'(ok), 1);
            measure(h, l);
            chk($sformatf("R4 period for code %0d", TBL[k].code), h + l, int'(TBL[k].code));
            chk($sformatf("R5 high run for code %0d", TBL[k].code), h, int'(TBL[k].hi));
            chk($sformatf("R5 low run for code %0d", TBL[k].code), l, int'(TBL[k].lo));
         end
      end

      // R7: static to static takes effect on the next reference edge
      div_code = 5'd0;
      wait_cycles(3);
      div_code = 5'd1;
      smp(c);
      chk("R7 static code change on next edge", int'(c), 1);

      // R7: a change in the middle of a period waits for its end
      div_code = 5'd6;
      wait_cycles(4);
      find_rise(ok);
      div_code = 5'd2;
      measure(h, l);
      chk("R7 old high run kept", h, 3);
      chk("R7 old low run kept", l, 3);
      measure(h, l);
      chk("R7 new period after boundary", h + l, 2);

      // R7/R8: flag drops only when the old period ends
      div_code = 5'd6;
      wait_cycles(4);
      find_rise(ok);
      div_code = 5'd0;
      smp(c);
      chk("R8 flag held until period end", int'(div_active), 1);
      wait_cycles(8);
      chk("R8 flag low after switch to code 0", int'(div_active), 0);
      chk("R2 output low after switch to code 0", int'(sclk_out), 0);

      // R1: reset in the middle of divide operation
      div_code = 5'd4;
      wait_cycles(6);
      rst_n = 1'b0;
      #1;
      chk("R1 sclk_out after mid-run reset", int'(sclk_out), 0);
      chk("R1 div_active after mid-run reset", int'(div_active), 0);
      wait_cycles(2);
      rst_n = 1'b1;
      wait_cycles(2);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(10 * 150000);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule